// File: doc/BRIEF.md
# Coherence Sharing-Miss Classifier

This block models two processors, each owning a private tag-only cache of four direct-mapped lines. The caches hold no data. Each processor presents a request strobe, a write flag and a byte address on its own port. One cycle later the block reports how that access was classified. A write from one side removes the matching line from the other side's cache, which gives write-invalidate coherence.

When a line is removed this way, the cache keeps its tag. It also keeps an invalidated flag and a per-line mask of the element slots that the other processor has written since the removal. A line is 32 bytes and holds four 8-byte elements. When the owning processor next touches that line and misses, the block compares the accessed element with the mask. A match means the two processors really share the data. No match means the processors only share the line.

The classifier is intended for performance studies. Its per-port result shows whether a miss was forced by true data sharing or by the placement of unrelated data within one line.

Top module: `sharing_miss_classifier`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, both result strobes are low and both classes are 2'b00. Reset empties every line and clears every invalidated flag and every mask.
- R2: An accepted request produces a result strobe exactly one cycle later. The strobe is low in every other cycle. The class is 2'b00 (hit) when the line at index address[6:5] is present and its stored tag equals address[15:7].
- R3: A miss to a line with no matching invalidation record is reported as 2'b01 (other miss). Cold, conflict and capacity misses all fall in this class. A miss on a read or on a write loads the line.
- R4: A write on one port to a line present in the other port's cache removes that copy. It marks the copy invalidated and records a mask holding only the written element, which is address[4:3].
- R5: A miss to an invalidated line whose mask contains the accessed element is reported as 2'b10 (true sharing).
- R6: A miss to an invalidated line whose mask lacks the accessed element is reported as 2'b11 (false sharing).
- R7: Further writes by the other port to an invalidated line add their element bits to its mask.
- R8: A local reload of a line clears its invalidated flag and its mask. This includes replacement by a different tag at the same index.
- R9: A write whose line is neither present nor invalidated with a matching tag in the other cache changes nothing there.
- R10: When both ports write the same line in one cycle, port 0 keeps its copy. Port 1's copy ends invalidated, with port 0's element in the mask.
- R11: An access that meets a remote write to the same line in the same cycle is classified from the state before that cycle. The remote invalidation is then applied on top of any local reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req_vld | input | 1 | Port 0 request strobe |
| p0_req_wr | input | 1 | Port 0 request is a write |
| p0_req_addr | input | 16 | Port 0 byte address |
| p1_req_vld | input | 1 | Port 1 request strobe |
| p1_req_wr | input | 1 | Port 1 request is a write |
| p1_req_addr | input | 16 | Port 1 byte address |
| p0_res_vld | output | 1 | Port 0 result strobe, one cycle after the request |
| p0_res_cls | output | 2 | Port 0 class: 00 hit, 01 other miss, 10 true sharing, 11 false sharing |
| p1_res_vld | output | 1 | Port 1 result strobe |
| p1_res_cls | output | 2 | Port 1 class, same encoding |

## Verification
Two functions can land on one line in the same cycle. The first is a cache's own lookup and reload. The second is the invalidation caused by the other port's write, which includes the case where both ports write the same line together. The bench provokes each overlap by issuing both requests in one cycle. It checks the classes reported for that cycle against the pre-cycle state. It then judges the resulting line state by a follow-up access on each port, which must come back as a hit, true sharing or false sharing as predicted.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    CLS_HIT   = 2'b00,
    CLS_OTHER = 2'b01,
    CLS_TRUE  = 2'b10,
    CLS_FALSE = 2'b11
  } shm_cls_e;

  localparam int unsigned PORTS = 2;
endpackage

// File: rtl/shm_cache_bank.sv
module shm_cache_bank
  import shm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINES      = 4,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned ELEM_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_vld,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              rem_vld,
  input  logic [ADDR_W-1:0] rem_addr,
  output shm_cls_e          loc_cls,
  output logic [LINES-1:0]  line_live
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned EB_W  = $clog2(ELEM_BYTES);
  localparam int unsigned ELEMS = LINE_BYTES / ELEM_BYTES;
  localparam int unsigned EL_W  = $clog2(ELEMS);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ELEMS-1:0] elem_bit(input logic [ADDR_W-1:0] a);
    logic [EL_W-1:0] e;
    e = a[EB_W +: EL_W];
    return ELEMS'(1) << e;
  endfunction

  logic             vld_q [LINES];
  logic             inv_q [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [ELEMS-1:0] msk_q [LINES];

  logic             vld_d [LINES];
  logic             inv_d [LINES];
  logic [TAG_W-1:0] tag_d [LINES];
  logic [ELEMS-1:0] msk_d [LINES];

  logic [IDX_W-1:0] lidx, ridx;
  logic [TAG_W-1:0] ltag, rtag;
  logic [ELEMS-1:0] lbit, rbit;
  logic             loc_hit, loc_coh, rem_inval_ev, rem_tag_seen, same_idx;

  assign lidx = idx_of(loc_addr);
  assign ltag = tag_of(loc_addr);
  assign lbit = elem_bit(loc_addr);
  assign ridx = idx_of(rem_addr);
  assign rtag = tag_of(rem_addr);
  assign rbit = elem_bit(rem_addr);

  assign loc_hit      = vld_q[lidx] && (tag_q[lidx] == ltag);
  assign loc_coh      = !loc_hit && inv_q[lidx] && (tag_q[lidx] == ltag);
  assign rem_inval_ev = rem_vld && vld_q[ridx] && (tag_q[ridx] == rtag);
  assign rem_tag_seen = (vld_q[ridx] || inv_q[ridx]) && (tag_q[ridx] == rtag);
  assign same_idx     = loc_vld && (lidx == ridx);

  always_comb begin
    if (loc_hit)                      loc_cls = CLS_HIT;
    else if (loc_coh && |(msk_q[lidx] & lbit)) loc_cls = CLS_TRUE;
    else if (loc_coh)                 loc_cls = CLS_FALSE;
    else                              loc_cls = CLS_OTHER;
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      vld_d[i] = vld_q[i];
      inv_d[i] = inv_q[i];
      tag_d[i] = tag_q[i];
      msk_d[i] = msk_q[i];
      if (loc_vld && (lidx == IDX_W'(i)) && !loc_hit) begin
        vld_d[i] = 1'b1;
        inv_d[i] = 1'b0;
        tag_d[i] = ltag;
        msk_d[i] = '0;
      end
      if (rem_vld && (ridx == IDX_W'(i)) && (tag_d[i] == rtag)) begin
        if (vld_d[i]) begin
          vld_d[i] = 1'b0;
          inv_d[i] = 1'b1;
          msk_d[i] = rbit;
        end else if (inv_d[i]) begin
          msk_d[i] = msk_d[i] | rbit;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= 1'b0;
        inv_q[i] <= 1'b0;
        tag_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= vld_d[i];
        inv_q[i] <= inv_d[i];
        tag_q[i] <= tag_d[i];
        msk_q[i] <= msk_d[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) line_live[i] = vld_q[i];
  end

  assert_fill_installs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_vld && !(rem_vld && (ridx == lidx))) |=> (vld_q[$past(lidx)] && (tag_q[$past(lidx)] == $past(ltag))));

  assert_remote_invalidates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_inval_ev && !same_idx) |=> (!vld_q[$past(ridx)] && inv_q[$past(ridx)] && (msk_q[$past(ridx)] == $past(rbit))));

  assert_mask_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_vld && inv_q[ridx] && (tag_q[ridx] == rtag) && !same_idx) |=> ((msk_q[$past(ridx)] & $past(rbit)) == $past(rbit)));

  assert_foreign_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_vld && !rem_tag_seen && !same_idx) |=> ((vld_q[$past(ridx)] == $past(vld_q[ridx])) &&
      (inv_q[$past(ridx)] == $past(inv_q[ridx])) && (msk_q[$past(ridx)] == $past(msk_q[ridx]))));

  assert_flag_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!(vld_q[$past(lidx)] && inv_q[$past(lidx)]) && (inv_q[$past(lidx)] == (msk_q[$past(lidx)] != '0))));
endmodule

// File: rtl/shm_result_reg.sv
module shm_result_reg
  import shm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_vld,
  input  shm_cls_e in_cls,
  output logic     out_vld,
  output shm_cls_e out_cls
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_cls <= CLS_HIT;
    end else begin
      out_vld <= in_vld;
      out_cls <= in_vld ? in_cls : CLS_HIT;
    end
  end

  assert_res_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_vld == $past(in_vld)));

  assert_idle_class_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_cls == CLS_HIT));
endmodule

// File: rtl/sharing_miss_classifier.sv
module sharing_miss_classifier
  import shm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINES      = 4,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned ELEM_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req_vld,
  input  logic              p0_req_wr,
  input  logic [ADDR_W-1:0] p0_req_addr,
  input  logic              p1_req_vld,
  input  logic              p1_req_wr,
  input  logic [ADDR_W-1:0] p1_req_addr,
  output logic              p0_res_vld,
  output logic [1:0]        p0_res_cls,
  output logic              p1_res_vld,
  output logic [1:0]        p1_res_cls
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W = $clog2(LINES);

  logic              req_vld [PORTS];
  logic              req_wr  [PORTS];
  logic [ADDR_W-1:0] req_addr[PORTS];
  logic              rem_en  [PORTS];
  logic              res_vld [PORTS];
  shm_cls_e          res_cls [PORTS];
  shm_cls_e          look_cls[PORTS];
  logic [LINES-1:0]  live    [PORTS];
  logic              wr_ev   [PORTS];
  logic              same_line, dual_write_ev;
  logic [IDX_W-1:0]  p0_idx;

  assign req_vld[0]  = p0_req_vld;
  assign req_wr[0]   = p0_req_wr;
  assign req_addr[0] = p0_req_addr;
  assign req_vld[1]  = p1_req_vld;
  assign req_wr[1]   = p1_req_wr;
  assign req_addr[1] = p1_req_addr;

  assign wr_ev[0]      = p0_req_vld && p0_req_wr;
  assign wr_ev[1]      = p1_req_vld && p1_req_wr;
  assign same_line     = (p0_req_addr[ADDR_W-1:OFF_W] == p1_req_addr[ADDR_W-1:OFF_W]);
  assign dual_write_ev = wr_ev[0] && wr_ev[1] && same_line;
  assign p0_idx        = p0_req_addr[OFF_W +: IDX_W];

  // Port 0 wins a same-line dual write: port 1's write does not reach bank 0.
  assign rem_en[0] = wr_ev[1] && !dual_write_ev;
  assign rem_en[1] = wr_ev[0];

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    shm_cache_bank #(
      .ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES), .ELEM_BYTES(ELEM_BYTES)
    ) bank_i (
      .clk(clk), .rst_n(rst_n),
      .loc_vld(req_vld[g]), .loc_addr(req_addr[g]),
      .rem_vld(rem_en[g]), .rem_addr(req_addr[PORTS-1-g]),
      .loc_cls(look_cls[g]), .line_live(live[g])
    );
    shm_result_reg res_i (
      .clk(clk), .rst_n(rst_n),
      .in_vld(req_vld[g]), .in_cls(look_cls[g]),
      .out_vld(res_vld[g]), .out_cls(res_cls[g])
    );
  end

  assign p0_res_vld = res_vld[0];
  assign p0_res_cls = res_cls[0];
  assign p1_res_vld = res_vld[1];
  assign p1_res_cls = res_cls[1];

  assert_p0_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dual_write_ev |=> (live[0][$past(p0_idx)] && !live[1][$past(p0_idx)]));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!p0_res_vld && !p1_res_vld && p0_res_cls == 2'b00 && p1_res_cls == 2'b00));
endmodule

// File: tb/sharing_miss_classifier_tb_top.sv
module sharing_miss_classifier_tb_top;
  localparam logic [1:0] HIT = 2'b00, OTH = 2'b01, TRU = 2'b10, FLS = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p0_req_vld = 1'b0, p0_req_wr = 1'b0;
  logic [15:0] p0_req_addr = '0;
  logic        p1_req_vld = 1'b0, p1_req_wr = 1'b0;
  logic [15:0] p1_req_addr = '0;
  logic        p0_res_vld, p1_res_vld;
  logic [1:0]  p0_res_cls, p1_res_cls;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  sharing_miss_classifier dut_i (
    .clk(clk), .rst_n(rst_n),
    .p0_req_vld(p0_req_vld), .p0_req_wr(p0_req_wr), .p0_req_addr(p0_req_addr),
    .p1_req_vld(p1_req_vld), .p1_req_wr(p1_req_wr), .p1_req_addr(p1_req_addr),
    .p0_res_vld(p0_res_vld), .p0_res_cls(p0_res_cls),
    .p1_res_vld(p1_res_vld), .p1_res_cls(p1_res_cls)
  );

  // tag in [15:7], line index in [6:5], element in [4:3]
  function automatic logic [15:0] mk(input int tag, input int idx, input int el);
    return {9'(tag), 2'(idx), 2'(el), 3'b000};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual vld/cls=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one cycle of requests, return after the result is registered
  task automatic go(input logic v0, input logic w0, input logic [15:0] a0,
                    input logic v1, input logic w1, input logic [15:0] a1);
    p0_req_vld = v0; p0_req_wr = w0; p0_req_addr = a0;
    p1_req_vld = v1; p1_req_wr = w1; p1_req_addr = a1;
    @(negedge clk);
    p0_req_vld = 1'b0; p1_req_vld = 1'b0;
  endtask

  task automatic op0(input logic w, input logic [15:0] a, input logic [1:0] e, input string req);
    go(1'b1, w, a, 1'b0, 1'b0, '0);
    check(req, {p0_res_vld, p0_res_cls}, {1'b1, e});
  endtask

  task automatic op1(input logic w, input logic [15:0] a, input logic [1:0] e, input string req);
    go(1'b0, 1'b0, '0, 1'b1, w, a);
    check(req, {p1_res_vld, p1_res_cls}, {1'b1, e});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 p0 in reset", {p0_res_vld, p0_res_cls}, 3'b000);
    check("R1 p1 in reset", {p1_res_vld, p1_res_cls}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 p0 after reset", {p0_res_vld, p0_res_cls}, 3'b000);
    check("R1 p1 after reset", {p1_res_vld, p1_res_cls}, 3'b000);
  endtask

  task automatic t_cold_hit;
    op0(1'b0, mk(1, 0, 0), OTH, "R3 cold read");
    op0(1'b0, mk(1, 0, 1), HIT, "R2 hit same line");
    op0(1'b1, mk(1, 0, 2), HIT, "R2 write hit");
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R2 no request p0", {p0_res_vld, p0_res_cls}, 3'b000);
    check("R2 no request p1", {p1_res_vld, p1_res_cls}, 3'b000);
  endtask

  task automatic t_true;
    op0(1'b0, mk(2, 1, 0), OTH, "R3 fill");
    op1(1'b1, mk(2, 1, 0), OTH, "R3 p1 write miss");
    op0(1'b0, mk(2, 1, 0), TRU, "R5 same element");
    op0(1'b0, mk(2, 1, 0), HIT, "R8 reload clears");
  endtask

  task automatic t_false;
    op0(1'b0, mk(3, 2, 0), OTH, "R3 fill");
    op1(1'b1, mk(3, 2, 1), OTH, "R3 p1 write miss");
    op0(1'b0, mk(3, 2, 0), FLS, "R6 other element");
  endtask

  task automatic t_accum;
    op0(1'b0, mk(4, 3, 0), OTH, "R3 fill");
    op1(1'b1, mk(4, 3, 1), OTH, "R4 first remote write");
    op1(1'b1, mk(4, 3, 2), HIT, "R7 second remote write");
    op0(1'b0, mk(4, 3, 2), TRU, "R7 accumulated element");
    op0(1'b0, mk(4, 3, 2), HIT, "R8 refilled");
    op1(1'b1, mk(4, 3, 3), HIT, "R4 new remote write");
    op0(1'b0, mk(4, 3, 2), FLS, "R8 old mask bits cleared");
  endtask

  task automatic t_conflict;
    op0(1'b0, mk(5, 0, 0), OTH, "R3 fill");
    op1(1'b1, mk(5, 0, 1), OTH, "R3 p1 write");
    op0(1'b0, mk(6, 0, 0), OTH, "R3 conflict replace");
    op0(1'b0, mk(5, 0, 1), OTH, "R8 replacement drops record");
  endtask

  task automatic t_foreign;
    op1(1'b1, mk(7, 1, 0), OTH, "R3 p1 write other tag");
    op0(1'b0, mk(2, 1, 3), HIT, "R9 held line untouched");
    op0(1'b0, mk(7, 1, 0), OTH, "R9 no record created");
  endtask

  task automatic t_both_write;
    go(1'b1, 1'b0, mk(8, 2, 0), 1'b1, 1'b0, mk(8, 2, 0));
    check("R3 dual fill p0", {p0_res_vld, p0_res_cls}, {1'b1, OTH});
    check("R3 dual fill p1", {p1_res_vld, p1_res_cls}, {1'b1, OTH});
    go(1'b1, 1'b1, mk(8, 2, 0), 1'b1, 1'b1, mk(8, 2, 1));
    check("R10 dual write p0", {p0_res_vld, p0_res_cls}, {1'b1, HIT});
    check("R10 dual write p1", {p1_res_vld, p1_res_cls}, {1'b1, HIT});
    op0(1'b0, mk(8, 2, 1), HIT, "R10 p0 keeps copy");
    op1(1'b0, mk(8, 2, 1), FLS, "R10 p1 invalidated by p0 element");
  endtask

  task automatic t_same_cycle;
    op0(1'b0, mk(9, 3, 1), OTH, "R3 fill");
    go(1'b1, 1'b0, mk(9, 3, 1), 1'b1, 1'b1, mk(9, 3, 1));
    check("R11 p0 read vs write", {p0_res_vld, p0_res_cls}, {1'b1, HIT});
    check("R11 p1 write miss", {p1_res_vld, p1_res_cls}, {1'b1, OTH});
    op0(1'b0, mk(9, 3, 1), TRU, "R11 invalidation after lookup");
    go(1'b1, 1'b1, mk(10, 0, 2), 1'b1, 1'b0, mk(10, 0, 0));
    check("R11 p0 write fill", {p0_res_vld, p0_res_cls}, {1'b1, OTH});
    check("R11 p1 read fill", {p1_res_vld, p1_res_cls}, {1'b1, OTH});
    op1(1'b0, mk(10, 0, 0), FLS, "R11 fill then invalidate");
  endtask

  task automatic t_p1_side;
    op1(1'b0, mk(11, 1, 3), OTH, "R3 p1 fill");
    op0(1'b1, mk(11, 1, 3), OTH, "R3 p0 write miss");
    op1(1'b0, mk(11, 1, 3), TRU, "R5 p1 true sharing");
  endtask

  task automatic t_write_class;
    op0(1'b0, mk(12, 2, 0), OTH, "R3 fill");
    op1(1'b1, mk(12, 2, 2), OTH, "R4 p1 write");
    op0(1'b1, mk(12, 2, 2), TRU, "R5 write miss classified");
    op1(1'b0, mk(12, 2, 0), FLS, "R4 p0 write invalidates p1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cold_hit();
    t_idle();
    t_true();
    t_false();
    t_accum();
    t_conflict();
    t_foreign();
    t_both_write();
    t_same_cycle();
    t_p1_side();
    t_write_class();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule